// File: doc/BRIEF.md
# Serial Calibration Register Port

This block is a serial slave that lets an external host read and write two 24-bit calibration words, one holding an offset and one holding a gain. The host drives a serial clock, a data line and an active-low select. The block samples all of them with its own system clock and reacts to rising edges of the serial clock. The stored words are also presented on parallel outputs, so the rest of the chip can use them at any time.

A transaction opens with an 8-bit command, sent most significant bit first. A write command is followed at once by a 24-bit word, also most significant bit first, which replaces the chosen register. A read command makes the block shift the chosen register out on the serial output. Each bit changes just after a rising serial clock edge and stays put until after the next one, where the host latches it. Commands are honoured only while the port-mode input selects the slave-clocked mode. Raising the select abandons whatever was under way.

Top module: `calport`

## Requirements
- R1: After reset the offset register reads 0x000000, the gain register reads 0x400000 and the serial output is low.
- R2: Command code 0x01 followed by 24 data bits, command and data sent MSB first and sampled on rising serial clock edges, loads those bits into the offset register. The new value is visible on the offset output.
- R3: Command code 0x02 followed by 24 data bits loads those bits into the gain register. The new value is visible on the gain output.
- R4: Command code 0x09 reads the offset register and 0x0A reads the gain register. Bit 23 is presented after the 8th rising edge, and each later rising edge presents the next lower bit. The host captures bit k on the rising edge after the one that presented it, so bit 0 is captured on the 32nd rising edge.
- R5: The serial output is low whenever no read data is being shifted. This covers the command phase, the time after the 24th read bit has been captured, and the time the select is high.
- R6: While the mode input is low, every command is ignored. Neither register changes and the serial output stays low.
- R7: A command code other than the four listed is ignored, and all bits after it are discarded until the select goes high.
- R8: Bits sent after a complete write or read, with the select still low, are discarded and change nothing.
- R9: Raising the select at any point aborts the transaction. A partly shifted write leaves the register unchanged, and the next transaction starts counting from its first command bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| csN | input | 1 | Active-low select |
| secMode | input | 1 | High enables register access (slave-clocked mode) |
| sdo | output | 1 | Serial read data, low when idle |
| offsetVal | output | 24 | Current offset register contents |
| gainVal | output | 24 | Current gain register contents |

## Verification
The bench builds the block with its default parameters: 24-bit words, two synchronizer stages and the reset values from R1. With these values the full 32-edge read frame and the exact rising edge that hands over each bit can be checked. The bench toggles the serial clock every four system clocks, which leaves room for the synchronizer and edge-detect latency before each capture. Directed frames cover these cases: MSB and LSB patterns, all-ones and all-zeros, a write cut short halfway, an unknown code, trailing bits, and mode-disabled access.

// File: rtl/calport_pkg.sv
package calport_pkg;

  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CMD_WR_OFS  = 8'h01;
  localparam logic [CMD_W-1:0] CMD_WR_GAIN = 8'h02;
  localparam logic [CMD_W-1:0] CMD_RD_OFS  = 8'h09;
  localparam logic [CMD_W-1:0] CMD_RD_GAIN = 8'h0A;

  typedef enum logic [1:0] {
    ST_CMD   = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_SKIP  = 2'd3
  } portState_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadOffset;
    logic loadGain;
    logic loadRead;
    logic readSel;   // 0 offset, 1 gain
    logic shiftOut;
    logic clearOut;
  } dpCtl_t;

  function automatic opKind_e decodeOp(input logic [CMD_W-1:0] code);
    case (code)
      CMD_WR_OFS, CMD_WR_GAIN: decodeOp = OP_WRITE;
      CMD_RD_OFS, CMD_RD_GAIN: decodeOp = OP_READ;
      default:                 decodeOp = OP_NONE;
    endcase
  endfunction

  function automatic logic decodeSel(input logic [CMD_W-1:0] code);
    decodeSel = (code == CMD_WR_GAIN) || (code == CMD_RD_GAIN);
  endfunction

endpackage

// File: rtl/calport_sync.sv
module calport_sync #(
  parameter int           WIDTH   = 4,
  parameter int           STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stage[s] <= RST_VAL;
        end else if (s == 0) begin
          stage[s] <= din;
        end else begin
          stage[s] <= stage[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/calport_ctrl.sv
module calport_ctrl
  import calport_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkS,
  input  logic             csNS,
  input  logic             secModeS,
  input  logic [CMD_W-1:0] cmdNext,
  output dpCtl_t           ctl,
  output logic             sclkRise,
  output logic             csIdle
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  portState_e       state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic             sel, selNext;
  logic             sclkPrev;
  opKind_e          op;

  assign csIdle   = csNS;
  assign sclkRise = sclkS & ~sclkPrev;
  assign op       = decodeOp(cmdNext);

  always_comb begin
    ctl        = '0;
    stateNext  = state;
    bitCntNext = bitCnt;
    selNext    = sel;
    if (csIdle) begin
      ctl.clearOut = 1'b1;
      stateNext    = ST_CMD;
      bitCntNext   = '0;
      selNext      = 1'b0;
    end else if (sclkRise) begin
      case (state)
        ST_CMD: begin
          ctl.shiftIn = 1'b1;
          bitCntNext  = bitCnt + 1'b1;
          if (bitCnt == CMD_LAST) begin
            bitCntNext = '0;
            selNext    = decodeSel(cmdNext);
            if (!secModeS) begin
              stateNext = ST_SKIP;
            end else if (op == OP_WRITE) begin
              stateNext = ST_WRITE;
            end else if (op == OP_READ) begin
              stateNext    = ST_READ;
              ctl.loadRead = 1'b1;
              ctl.readSel  = decodeSel(cmdNext);
            end else begin
              stateNext = ST_SKIP;
            end
          end
        end
        ST_WRITE: begin
          ctl.shiftIn = 1'b1;
          bitCntNext  = bitCnt + 1'b1;
          if (bitCnt == DATA_LAST) begin
            ctl.loadOffset = ~sel;
            ctl.loadGain   = sel;
            bitCntNext     = '0;
            stateNext      = ST_SKIP;
          end
        end
        ST_READ: begin
          bitCntNext = bitCnt + 1'b1;
          if (bitCnt == DATA_LAST) begin
            ctl.clearOut = 1'b1;
            bitCntNext   = '0;
            stateNext    = ST_SKIP;
          end else begin
            ctl.shiftOut = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_CMD;
      bitCnt   <= '0;
      sel      <= 1'b0;
      sclkPrev <= 1'b0;
    end else begin
      state    <= stateNext;
      bitCnt   <= bitCntNext;
      sel      <= selNext;
      sclkPrev <= sclkS;
    end
  end

endmodule

// File: rtl/calport_dp.sv
module calport_dp
  import calport_pkg::*;
#(
  parameter int                DATA_W     = 24,
  parameter logic [DATA_W-1:0] OFFSET_RST = '0,
  parameter logic [DATA_W-1:0] GAIN_RST   = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdiS,
  input  dpCtl_t            ctl,
  output logic [CMD_W-1:0]  cmdNext,
  output logic              sdo,
  output logic [DATA_W-1:0] offsetVal,
  output logic [DATA_W-1:0] gainVal
);

  logic [DATA_W-1:0] inShift;
  logic [DATA_W-1:0] outShift;
  logic [DATA_W-1:0] wordNext;
  logic [DATA_W-1:0] readSrc;

  assign wordNext = {inShift[DATA_W-2:0], sdiS};
  assign cmdNext  = wordNext[CMD_W-1:0];
  assign readSrc  = ctl.readSel ? gainVal : offsetVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift <= '0;
    end else if (ctl.shiftIn) begin
      inShift <= wordNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offsetVal <= OFFSET_RST;
      gainVal   <= GAIN_RST;
    end else begin
      if (ctl.loadOffset) offsetVal <= wordNext;
      if (ctl.loadGain)   gainVal   <= wordNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      sdo      <= 1'b0;
    end else if (ctl.clearOut) begin
      outShift <= '0;
      sdo      <= 1'b0;
    end else if (ctl.loadRead) begin
      sdo      <= readSrc[DATA_W-1];
      outShift <= {readSrc[DATA_W-2:0], 1'b0};
    end else if (ctl.shiftOut) begin
      sdo      <= outShift[DATA_W-1];
      outShift <= {outShift[DATA_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/calport.sv
module calport
  import calport_pkg::*;
#(
  parameter int                DATA_W      = 24,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] OFFSET_RST  = 24'h000000,
  parameter logic [DATA_W-1:0] GAIN_RST    = 24'h400000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              csN,
  input  logic              secMode,
  output logic              sdo,
  output logic [DATA_W-1:0] offsetVal,
  output logic [DATA_W-1:0] gainVal
);

  localparam int PIN_W = 4;
  localparam logic [PIN_W-1:0] PIN_RST = 4'b0100; // csN idles high

  logic [PIN_W-1:0] pinsS;
  logic [CMD_W-1:0] cmdNext;
  dpCtl_t           ctl;
  logic             sclkRise;
  logic             csIdle;

  calport_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({secMode, csN, sdi, sclk}),
    .dout(pinsS)
  );

  calport_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclkS   (pinsS[0]),
    .csNS    (pinsS[2]),
    .secModeS(pinsS[3]),
    .cmdNext (cmdNext),
    .ctl     (ctl),
    .sclkRise(sclkRise),
    .csIdle  (csIdle)
  );

  calport_dp #(
    .DATA_W    (DATA_W),
    .OFFSET_RST(OFFSET_RST),
    .GAIN_RST  (GAIN_RST)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sdiS     (pinsS[1]),
    .ctl      (ctl),
    .cmdNext  (cmdNext),
    .sdo      (sdo),
    .offsetVal(offsetVal),
    .gainVal  (gainVal)
  );

endmodule

// File: rtl/calport_chk.sv
module calport_chk
  import calport_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdo,
  input logic [DATA_W-1:0] offsetVal,
  input logic [DATA_W-1:0] gainVal,
  input dpCtl_t            ctl,
  input logic              sclkRise,
  input logic              csIdle
);

  AST_SDO_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    csIdle |=> !sdo); // R5

  AST_OFFSET_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (offsetVal != $past(offsetVal)) |-> $past(ctl.loadOffset)); // R2

  AST_GAIN_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (gainVal != $past(gainVal)) |-> $past(ctl.loadGain)); // R3

  AST_LOADS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadOffset, ctl.loadGain, ctl.loadRead})); // R8

  AST_LOAD_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadOffset || ctl.loadGain || ctl.loadRead) |-> (sclkRise && !csIdle)); // R9

endmodule

bind calport calport_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sdo      (sdo),
  .offsetVal(offsetVal),
  .gainVal  (gainVal),
  .ctl      (ctl),
  .sclkRise (sclkRise),
  .csIdle   (csIdle)
);

// File: tb/calport_bench.sv
module calport_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;   // system clocks per serial half period
  localparam int DW         = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sclk = 1'b0;
  logic          sdi = 1'b0;
  logic          csN = 1'b1;
  logic          secMode = 1'b1;
  logic          sdo;
  logic [DW-1:0] offsetVal;
  logic [DW-1:0] gainVal;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  calport u_calport (
    .clk      (clk),
    .rstN     (rstN),
    .sclk     (sclk),
    .sdi      (sdi),
    .csN      (csN),
    .secMode  (secMode),
    .sdo      (sdo),
    .offsetVal(offsetVal),
    .gainVal  (gainVal)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic selectOn();
    @(negedge clk);
    csN = 1'b0;
    waitClk(4);
  endtask

  task automatic selectOff();
    @(negedge clk);
    sclk = 1'b0;
    csN  = 1'b1;
    waitClk(8);
  endtask

  // shifts n bits MSB first; got holds sdo sampled just before each rise
  task automatic xfer(input logic [31:0] bits, input int n, output logic [31:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sdi = bits[n-1-i];
      waitClk(HALF_SCLK);
      got[n-1-i] = sdo;
      sclk = 1'b1;
      waitClk(HALF_SCLK);
      sclk = 1'b0;
    end
  endtask

  task automatic writeReg(input logic [7:0] code, input logic [DW-1:0] val);
    logic [31:0] g;
    selectOn();
    xfer({code, val}, 32, g);
    selectOff();
  endtask

  task automatic readReg(input logic [7:0] code, output logic [31:0] got);
    selectOn();
    xfer({code, 24'h0}, 32, got);
    waitClk(HALF_SCLK);
    check(sdo == 1'b0, "R5 sdo after last bit", {31'b0, sdo}, 0);
    selectOff();
  endtask

  task automatic testReset();
    check(offsetVal == 24'h000000, "R1 offset reset", offsetVal, 0);
    check(gainVal == 24'h400000, "R1 gain reset", gainVal, 32'h400000);
    check(sdo == 1'b0, "R1 sdo reset", {31'b0, sdo}, 0);
  endtask

  task automatic testWrites();
    writeReg(8'h01, 24'h123456);
    check(offsetVal == 24'h123456, "R2 offset write", offsetVal, 32'h123456);
    check(gainVal == 24'h400000, "R2 gain untouched", gainVal, 32'h400000);
    writeReg(8'h02, 24'hABCDEF);
    check(gainVal == 24'hABCDEF, "R3 gain write", gainVal, 32'hABCDEF);
    check(offsetVal == 24'h123456, "R3 offset untouched", offsetVal, 32'h123456);
  endtask

  task automatic testReads();
    logic [31:0] g;
    writeReg(8'h01, 24'h800001);
    readReg(8'h09, g);
    check(g[23:0] == 24'h800001, "R4 read offset", g[23:0], 32'h800001);
    check(g[31:24] == 8'h00, "R5 sdo low in command phase", g[31:24], 0);
    readReg(8'h0A, g);
    check(g[23:0] == 24'hABCDEF, "R4 read gain", g[23:0], 32'hABCDEF);
    writeReg(8'h02, 24'hFFFFFF);
    readReg(8'h0A, g);
    check(g[23:0] == 24'hFFFFFF, "R4 read all ones", g[23:0], 32'hFFFFFF);
    writeReg(8'h02, 24'h000000);
    readReg(8'h0A, g);
    check(g[23:0] == 24'h000000, "R4 read all zeros", g[23:0], 0);
    check(gainVal == 24'h000000, "R3 gain zero", gainVal, 0);
  endtask

  task automatic testModeOff();
    logic [31:0] g;
    secMode = 1'b0;
    writeReg(8'h01, 24'h555555);
    check(offsetVal == 24'h800001, "R6 write ignored", offsetVal, 32'h800001);
    selectOn();
    xfer({8'h09, 24'h0}, 32, g);
    selectOff();
    check(g == 32'h0, "R6 read ignored sdo low", g, 0);
    secMode = 1'b1;
    waitClk(4);
  endtask

  task automatic testBadCode();
    logic [31:0] g;
    selectOn();
    xfer({8'h05, 24'h111111}, 32, g);
    xfer({8'h01, 24'h222222}, 32, g);
    check(g == 32'h0, "R7 sdo low after bad code", g, 0);
    selectOff();
    check(offsetVal == 24'h800001, "R7 offset unchanged", offsetVal, 32'h800001);
    check(gainVal == 24'h000000, "R7 gain unchanged", gainVal, 0);
  endtask

  task automatic testTrailing();
    logic [31:0] g;
    selectOn();
    xfer({8'h01, 24'h0F0F0F}, 32, g);
    xfer({8'h02, 24'h333333}, 32, g);
    selectOff();
    check(offsetVal == 24'h0F0F0F, "R8 first write kept", offsetVal, 32'h0F0F0F);
    check(gainVal == 24'h000000, "R8 trailing write dropped", gainVal, 0);
    selectOn();
    xfer({8'h09, 24'h0}, 32, g);
    xfer(32'h0, 16, g);
    check(g[15:0] == 16'h0, "R8 sdo low after read frame", g[15:0], 0);
    selectOff();
  endtask

  task automatic testAbort();
    logic [31:0] g;
    selectOn();
    xfer({8'h01, 12'hABC}, 20, g);
    selectOff();
    check(offsetVal == 24'h0F0F0F, "R9 partial write discarded", offsetVal, 32'h0F0F0F);
    writeReg(8'h01, 24'h13579B);
    check(offsetVal == 24'h13579B, "R9 fresh write after abort", offsetVal, 32'h13579B);
    selectOn();
    xfer({8'h09, 4'h0}, 12, g);
    selectOff();
    check(sdo == 1'b0, "R9 sdo low after aborted read", {31'b0, sdo}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin : main
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testWrites();
    testReads();
    testModeOff();
    testBadCode();
    testTrailing();
    testAbort();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule